// File: doc/BRIEF.md
# Write-Through Bypass RAM

This block is a single-clock synchronous RAM with one registered read port and two byte-enabled write ports. On its own, the storage array behaves as read-before-write: a read that hits the word being written in the same cycle returns the old contents. Around the array, optional bypass stages make the read port write-through (transparent) toward either write port. Two parameters choose which write ports get this behaviour, so one RAM can serve both a forwarding use and a plain old-data use.

Each bypass stage keeps two registers, both loaded on the read enable. One is a copy of the write data. The other is a set of flags, one per read-width lane, that record whether that lane of the write hit the word being read. The flags follow the read port's reset rules. Each flag drives a lane mux at the array output. The write ports are wider than the read port by a fixed power-of-two ratio. Each read-width sub-word of a write gets its own address compare and its own slice of the captured data.

Write port B has priority over write port A. When both ports write the same lane of the same word, A's byte enable is masked, so only B's data is stored. The B bypass stage sits nearer the output than the A stage.

Top module: `wt_bypass_ram`

## Requirements
- R1: While `rst` is high at a rising edge, `rd_data` is all zeros after that edge, whatever the other inputs are.
- R2: With `rd_en` high and no reset, `rd_data` after the edge is read word `rd_addr`. Read word i is bits [(i mod 2^WIDE_LOG2)*RD_DATA_W +: RD_DATA_W] of write-port word i >> WIDE_LOG2. Write byte-enable bit l covers write-data bits [l*LANE_W +: LANE_W].
- R3: With `rd_en` low and no reset firing, `rd_data` keeps its value, even when writes change the word last read.
- R4: A read-port reset loads `SRST_VAL` into `rd_data` at the edge. With rule SRST_ALWAYS it acts even when `rd_en` is low. With rule SRST_WITH_EN it acts only together with `rd_en`, and otherwise `rd_data` holds.
- R5: For a write port whose transparency parameter is 0, a same-cycle read of the word it writes returns the contents from before the write.
- R6: For a write port whose transparency parameter is 1, a same-cycle read returns the new data in every lane whose byte enable is set, and the old data in the other lanes.
- R7: When both ports write the same lane of the same word in one cycle, the array stores port B's data.
- R8: With both ports transparent and both writing the same lane of the word being read, that lane of `rd_data` shows port B's data.
- R9: With A transparent and B not, a lane written by both ports in the read cycle shows the old data, because A's write to that lane is discarded.
- R10: A write changes only the read sub-words its byte enables cover. A read of the other sub-word of the same write word shows no bypassed data in lanes whose byte enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all ports |
| rst | input | 1 | Synchronous active-high reset of the read path |
| rd_en | input | 1 | Read enable |
| rd_srst | input | 1 | Read-port synchronous reset to SRST_VAL |
| rd_addr | input | RD_ADDR_W | Read word address |
| rd_data | output | RD_DATA_W | Read data, one cycle after the read |
| wa_be | input | WR_LANES | Port A lane enables (lower priority) |
| wa_addr | input | RD_ADDR_W-WIDE_LOG2 | Port A word address |
| wa_data | input | RD_DATA_W<<WIDE_LOG2 | Port A write data |
| wb_be | input | WR_LANES | Port B lane enables (higher priority) |
| wb_addr | input | RD_ADDR_W-WIDE_LOG2 | Port B word address |
| wb_data | input | RD_DATA_W<<WIDE_LOG2 | Port B write data |

## Verification
The assertions check on every cycle the behaviours that depend only on the ports: the zero after reset, the loaded reset value, the held output while reads are idle, and whole-sub-word forwarding from each transparent port, with B winning over A. Lane-wise mixing of old and new data, the old-data result toward a non-transparent port, the lost low-priority write, and the stored array contents need a reference memory. Only the bench's sweeps over read address, write address and lane-enable pattern can show these. Two instances, one fully transparent and one transparent only to A, are driven in step so that both pairings are seen under the same collisions.

// File: rtl/wt_bypass_pkg.sv
package wt_bypass_pkg;
  // Precedence between read enable and the read-port synchronous reset.
  typedef enum logic {
    SRST_ALWAYS  = 1'b0,  // reset acts regardless of rd_en
    SRST_WITH_EN = 1'b1   // reset acts only when rd_en is high
  } srst_rule_e;
endpackage

// File: rtl/wt_write_arb.sv
module wt_write_arb #(
  parameter int WR_ADDR_W = 3,
  parameter int WR_LANES  = 4
) (
  input  logic [WR_LANES-1:0]  a_be,
  input  logic [WR_ADDR_W-1:0] a_addr,
  input  logic [WR_LANES-1:0]  b_be,
  input  logic [WR_ADDR_W-1:0] b_addr,
  output logic [WR_LANES-1:0]  a_be_eff
);
  logic same_word;
  assign same_word = (a_addr == b_addr);
  // B owns any lane it writes at a shared address; A is masked there.
  assign a_be_eff = a_be & ~(b_be & {WR_LANES{same_word}});
endmodule

// File: rtl/wt_array.sv
module wt_array #(
  parameter int RD_ADDR_W = 4,
  parameter int RD_DATA_W = 16,
  parameter int LANE_W    = 8,
  parameter int WIDE_LOG2 = 1,
  parameter logic [RD_DATA_W-1:0] SRST_VAL = '0,
  localparam int WR_DATA_W = RD_DATA_W << WIDE_LOG2,
  localparam int WR_ADDR_W = RD_ADDR_W - WIDE_LOG2,
  localparam int WR_LANES  = WR_DATA_W / LANE_W,
  localparam int SUBS      = 1 << WIDE_LOG2,
  localparam int DEPTH     = 1 << WR_ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic                 srst_fire,
  input  logic [RD_ADDR_W-1:0] rd_addr,
  output logic [RD_DATA_W-1:0] rd_q,
  input  logic [WR_LANES-1:0]  a_be,
  input  logic [WR_ADDR_W-1:0] a_addr,
  input  logic [WR_DATA_W-1:0] a_data,
  input  logic [WR_LANES-1:0]  b_be,
  input  logic [WR_ADDR_W-1:0] b_addr,
  input  logic [WR_DATA_W-1:0] b_data
);
  logic [WR_DATA_W-1:0] mem [DEPTH];
  logic [WR_ADDR_W-1:0] r_word;
  logic [RD_ADDR_W-1:0] r_sub;

  assign r_word = WR_ADDR_W'(rd_addr >> WIDE_LOG2);
  assign r_sub  = rd_addr & RD_ADDR_W'(SUBS - 1);

  // Lane-wise writes; A's enables arrive already masked against B.
  always_ff @(posedge clk) begin
    for (int l = 0; l < WR_LANES; l++) begin
      if (a_be[l]) mem[a_addr][l*LANE_W +: LANE_W] <= a_data[l*LANE_W +: LANE_W];
      if (b_be[l]) mem[b_addr][l*LANE_W +: LANE_W] <= b_data[l*LANE_W +: LANE_W];
    end
  end

  // Registered read, old-data on collision.
  always_ff @(posedge clk) begin
    if (rst)            rd_q <= '0;
    else if (srst_fire) rd_q <= SRST_VAL;
    else if (rd_en)     rd_q <= mem[r_word][r_sub*RD_DATA_W +: RD_DATA_W];
  end
endmodule

// File: rtl/wt_bypass_stage.sv
module wt_bypass_stage #(
  parameter int RD_ADDR_W = 4,
  parameter int RD_DATA_W = 16,
  parameter int LANE_W    = 8,
  parameter int WIDE_LOG2 = 1,
  localparam int WR_DATA_W = RD_DATA_W << WIDE_LOG2,
  localparam int WR_ADDR_W = RD_ADDR_W - WIDE_LOG2,
  localparam int RD_LANES  = RD_DATA_W / LANE_W,
  localparam int WR_LANES  = WR_DATA_W / LANE_W,
  localparam int SUBS      = 1 << WIDE_LOG2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic                 srst_fire,
  input  logic [RD_ADDR_W-1:0] rd_addr,
  input  logic [WR_LANES-1:0]  w_be,
  input  logic [WR_ADDR_W-1:0] w_addr,
  input  logic [WR_DATA_W-1:0] w_data,
  input  logic [RD_DATA_W-1:0] din,
  output logic [RD_DATA_W-1:0] dout
);
  logic [WR_LANES-1:0]  hit_d;
  logic [WR_LANES-1:0]  hit_q;
  logic [WR_DATA_W-1:0] wdata_q;

  // One address compare per read-width sub-word of the write, one flag per lane.
  for (genvar s = 0; s < SUBS; s++) begin : g_sub
    logic [RD_ADDR_W-1:0] tgt;
    logic                 match;
    assign tgt   = (RD_ADDR_W'(w_addr) << WIDE_LOG2) | RD_ADDR_W'(s);
    assign match = (rd_addr == tgt);
    for (genvar k = 0; k < RD_LANES; k++) begin : g_lane
      assign hit_d[s*RD_LANES + k] = w_be[s*RD_LANES + k] & match;
    end
  end

  // Flags mirror the read port's enable and reset rules.
  always_ff @(posedge clk) begin
    if (rst || srst_fire) hit_q <= '0;
    else if (rd_en)       hit_q <= hit_d;
  end

  // Data copy: read enable only, no reset needed (masked by flags).
  always_ff @(posedge clk) begin
    if (rd_en) wdata_q <= w_data;
  end

  always_comb begin
    dout = din;
    for (int s = 0; s < SUBS; s++) begin
      for (int k = 0; k < RD_LANES; k++) begin
        if (hit_q[s*RD_LANES + k])
          dout[k*LANE_W +: LANE_W] = wdata_q[(s*RD_LANES + k)*LANE_W +: LANE_W];
      end
    end
  end
endmodule

// File: rtl/wt_bypass_ram.sv
module wt_bypass_ram
  import wt_bypass_pkg::*;
#(
  parameter int RD_ADDR_W = 4,
  parameter int RD_DATA_W = 16,
  parameter int LANE_W    = 8,
  parameter int WIDE_LOG2 = 1,
  parameter bit XPAR_A    = 1'b1,
  parameter bit XPAR_B    = 1'b1,
  parameter srst_rule_e SRST_RULE = SRST_ALWAYS,
  parameter logic [RD_DATA_W-1:0] SRST_VAL = '0,
  localparam int WR_DATA_W = RD_DATA_W << WIDE_LOG2,
  localparam int WR_ADDR_W = RD_ADDR_W - WIDE_LOG2,
  localparam int WR_LANES  = WR_DATA_W / LANE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic                 rd_srst,
  input  logic [RD_ADDR_W-1:0] rd_addr,
  output logic [RD_DATA_W-1:0] rd_data,
  input  logic [WR_LANES-1:0]  wa_be,
  input  logic [WR_ADDR_W-1:0] wa_addr,
  input  logic [WR_DATA_W-1:0] wa_data,
  input  logic [WR_LANES-1:0]  wb_be,
  input  logic [WR_ADDR_W-1:0] wb_addr,
  input  logic [WR_DATA_W-1:0] wb_data
);
  logic                 srst_fire;
  logic [WR_LANES-1:0]  a_be_eff;
  logic [RD_DATA_W-1:0] arr_q;
  logic [RD_DATA_W-1:0] after_a;

  assign srst_fire = rd_srst & ((SRST_RULE == SRST_ALWAYS) | rd_en);

  wt_write_arb #(.WR_ADDR_W(WR_ADDR_W), .WR_LANES(WR_LANES)) u_arb (
    .a_be(wa_be), .a_addr(wa_addr), .b_be(wb_be), .b_addr(wb_addr), .a_be_eff(a_be_eff)
  );

  wt_array #(
    .RD_ADDR_W(RD_ADDR_W), .RD_DATA_W(RD_DATA_W), .LANE_W(LANE_W),
    .WIDE_LOG2(WIDE_LOG2), .SRST_VAL(SRST_VAL)
  ) u_array (
    .clk(clk), .rst(rst), .rd_en(rd_en), .srst_fire(srst_fire),
    .rd_addr(rd_addr), .rd_q(arr_q),
    .a_be(a_be_eff), .a_addr(wa_addr), .a_data(wa_data),
    .b_be(wb_be), .b_addr(wb_addr), .b_data(wb_data)
  );

  // Lower-priority stage first; the B stage sits nearer the output.
  if (XPAR_A) begin : g_byp_a
    wt_bypass_stage #(
      .RD_ADDR_W(RD_ADDR_W), .RD_DATA_W(RD_DATA_W), .LANE_W(LANE_W), .WIDE_LOG2(WIDE_LOG2)
    ) u_stage (
      .clk(clk), .rst(rst), .rd_en(rd_en), .srst_fire(srst_fire), .rd_addr(rd_addr),
      .w_be(a_be_eff), .w_addr(wa_addr), .w_data(wa_data), .din(arr_q), .dout(after_a)
    );
  end else begin : g_pass_a
    assign after_a = arr_q;
  end

  if (XPAR_B) begin : g_byp_b
    wt_bypass_stage #(
      .RD_ADDR_W(RD_ADDR_W), .RD_DATA_W(RD_DATA_W), .LANE_W(LANE_W), .WIDE_LOG2(WIDE_LOG2)
    ) u_stage (
      .clk(clk), .rst(rst), .rd_en(rd_en), .srst_fire(srst_fire), .rd_addr(rd_addr),
      .w_be(wb_be), .w_addr(wb_addr), .w_data(wb_data), .din(after_a), .dout(rd_data)
    );
  end else begin : g_pass_b
    assign rd_data = after_a;
  end
endmodule

// File: rtl/wt_bypass_ram_chk.sv
module wt_bypass_ram_chk
  import wt_bypass_pkg::*;
#(
  parameter int RD_ADDR_W = 4,
  parameter int RD_DATA_W = 16,
  parameter int LANE_W    = 8,
  parameter int WIDE_LOG2 = 1,
  parameter bit XPAR_A    = 1'b1,
  parameter bit XPAR_B    = 1'b1,
  parameter srst_rule_e SRST_RULE = SRST_ALWAYS,
  parameter logic [RD_DATA_W-1:0] SRST_VAL = '0,
  localparam int WR_DATA_W = RD_DATA_W << WIDE_LOG2,
  localparam int WR_ADDR_W = RD_ADDR_W - WIDE_LOG2,
  localparam int WR_LANES  = WR_DATA_W / LANE_W
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rd_en,
  input logic                 rd_srst,
  input logic [RD_ADDR_W-1:0] rd_addr,
  input logic [RD_DATA_W-1:0] rd_data,
  input logic [WR_LANES-1:0]  wa_be,
  input logic [WR_ADDR_W-1:0] wa_addr,
  input logic [WR_DATA_W-1:0] wa_data,
  input logic [WR_LANES-1:0]  wb_be,
  input logic [WR_ADDR_W-1:0] wb_addr,
  input logic [WR_DATA_W-1:0] wb_data
);
  localparam int SUBS = 1 << WIDE_LOG2;
  localparam int RD_LANES = RD_DATA_W / LANE_W;

  logic [RD_ADDR_W-1:0] sub;
  logic [WR_ADDR_W-1:0] word;
  logic [RD_LANES-1:0]  a_sub_be, b_sub_be;
  logic [RD_DATA_W-1:0] a_slice, b_slice;
  logic                 srst_go;

  assign sub      = rd_addr & RD_ADDR_W'(SUBS - 1);
  assign word     = WR_ADDR_W'(rd_addr >> WIDE_LOG2);
  assign a_sub_be = RD_LANES'(wa_be >> (sub * RD_LANES));
  assign b_sub_be = RD_LANES'(wb_be >> (sub * RD_LANES));
  assign a_slice  = RD_DATA_W'(wa_data >> (sub * RD_DATA_W));
  assign b_slice  = RD_DATA_W'(wb_data >> (sub * RD_DATA_W));
  assign srst_go  = rd_srst && (SRST_RULE == SRST_ALWAYS || rd_en);

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> rd_data == '0); // R1

  AST_SRST_LOAD: assert property (@(posedge clk) disable iff (rst)
    srst_go |=> rd_data == SRST_VAL); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !rd_srst) |=> $stable(rd_data)); // R3

  if (XPAR_A) begin : g_a
    AST_A_FORWARD: assert property (@(posedge clk) disable iff (rst)
      (rd_en && !rd_srst && wa_addr == word && (&a_sub_be) && wb_be == '0)
      |=> rd_data == $past(a_slice)); // R6
  end

  if (XPAR_B) begin : g_b
    AST_B_FORWARD: assert property (@(posedge clk) disable iff (rst)
      (rd_en && !rd_srst && wb_addr == word && (&b_sub_be))
      |=> rd_data == $past(b_slice)); // R8
  end
endmodule

bind wt_bypass_ram wt_bypass_ram_chk #(
  .RD_ADDR_W(RD_ADDR_W), .RD_DATA_W(RD_DATA_W), .LANE_W(LANE_W), .WIDE_LOG2(WIDE_LOG2),
  .XPAR_A(XPAR_A), .XPAR_B(XPAR_B), .SRST_RULE(SRST_RULE), .SRST_VAL(SRST_VAL)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_srst(rd_srst), .rd_addr(rd_addr),
  .rd_data(rd_data), .wa_be(wa_be), .wa_addr(wa_addr), .wa_data(wa_data),
  .wb_be(wb_be), .wb_addr(wb_addr), .wb_data(wb_data)
);

// File: tb/wt_bypass_ram_tb.sv
module wt_bypass_ram_tb;
  import wt_bypass_pkg::*;

  localparam logic [15:0] SRV = 16'h5A3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0, rd_srst = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [3:0]  wa_be = '0, wb_be = '0;
  logic [2:0]  wa_addr = '0, wb_addr = '0;
  logic [31:0] wa_data = '0, wb_data = '0;
  logic [15:0] dout_t, dout_n;

  int checks = 0, errors = 0;
  logic [31:0] model [8];
  logic [15:0] exp_t = '0, exp_n = '0;

  always #5 clk = ~clk;

  // Fully transparent, reset always acts.
  wt_bypass_ram #(.XPAR_A(1'b1), .XPAR_B(1'b1), .SRST_RULE(SRST_ALWAYS), .SRST_VAL(SRV)) u_dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_srst(rd_srst), .rd_addr(rd_addr), .rd_data(dout_t),
    .wa_be(wa_be), .wa_addr(wa_addr), .wa_data(wa_data),
    .wb_be(wb_be), .wb_addr(wb_addr), .wb_data(wb_data));

  // Transparent only to A, reset gated by enable.
  wt_bypass_ram #(.XPAR_A(1'b1), .XPAR_B(1'b0), .SRST_RULE(SRST_WITH_EN), .SRST_VAL(SRV)) u_dut_nt (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_srst(rd_srst), .rd_addr(rd_addr), .rd_data(dout_n),
    .wa_be(wa_be), .wa_addr(wa_addr), .wa_data(wa_data),
    .wb_be(wb_be), .wb_addr(wb_addr), .wb_data(wb_data));

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [15:0] predict(bit xa, bit xb, bit gated, logic [15:0] prev);
    logic [15:0] v;
    int s, w;
    if (rst) return 16'h0;
    if (rd_srst && (!gated || rd_en)) return SRV;
    if (!rd_en) return prev;
    s = int'(rd_addr) % 2;
    w = int'(rd_addr) / 2;
    for (int k = 0; k < 2; k++) begin
      int l;
      bit bh, ah;
      l  = s * 2 + k;
      bh = wb_be[l] && (int'(wb_addr) == w);
      ah = wa_be[l] && (int'(wa_addr) == w) && !bh;
      v[k*8 +: 8] = model[w][l*8 +: 8];
      if (xa && ah) v[k*8 +: 8] = wa_data[l*8 +: 8];
      if (xb && bh) v[k*8 +: 8] = wb_data[l*8 +: 8];
    end
    return v;
  endfunction

  task automatic chk(string tag, string who, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", tag, who, got, exp, $time);
    end
  endtask

  task automatic step(string tag_t, string tag_n);
    exp_t = predict(1'b1, 1'b1, 1'b0, exp_t);
    exp_n = predict(1'b1, 1'b0, 1'b1, exp_n);
    @(posedge clk);
    #1;
    chk(tag_t, "u_dut", dout_t, exp_t);
    chk(tag_n, "u_dut_nt", dout_n, exp_n);
    for (int l = 0; l < 4; l++) begin
      if (wb_be[l]) model[wb_addr][l*8 +: 8] = wb_data[l*8 +: 8];
      else if (wa_be[l]) model[wa_addr][l*8 +: 8] = wa_data[l*8 +: 8];
      else if (wa_be[l] && wa_addr != wb_addr) model[wa_addr][l*8 +: 8] = wa_data[l*8 +: 8];
    end
    for (int l = 0; l < 4; l++)
      if (wa_be[l] && wb_be[l] && wa_addr != wb_addr) model[wa_addr][l*8 +: 8] = wa_data[l*8 +: 8];
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    rd_en = 1'b0; rd_srst = 1'b0; wa_be = '0; wb_be = '0;
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state
    rst = 1'b1; rd_en = 1'b1; rd_addr = 4'd3;
    step("R1", "R1");
    step("R1", "R1");
    rst = 1'b0; idle_inputs();

    // Fill memory through A with reads idle; R3 output holds at zero.
    for (int i = 0; i < 8; i++) begin
      wa_be = 4'hF; wa_addr = 3'(i); wa_data = 32'hA000_0000 + i * 32'h0101_0101;
      step("R3", "R3");
    end
    idle_inputs();

    // R2: plain reads of every read word.
    for (int r = 0; r < 16; r++) begin
      rd_en = 1'b1; rd_addr = 4'(r);
      step("R2", "R2");
    end

    // Sweep read address x write address x collision mode.
    for (int r = 0; r < 16; r++) begin
      for (int a = 0; a < 8; a++) begin
        for (int m = 0; m < 4; m++) begin
          int n;
          bit ah, bh;
          string tt, tn;
          n = (r * 8 + a) * 4 + m;
          rd_en = 1'b1; rd_addr = 4'(r);
          wa_addr = 3'(a); wa_data = 32'h1000_0000 + n * 32'h0003_0507;
          wb_data = 32'h2000_0000 + n * 32'h0709_0B0D;
          case (m)
            0: begin wa_be = 4'b0101; wb_be = 4'b0000; wb_addr = 3'(a); end
            1: begin wa_be = 4'b0000; wb_be = 4'b1010; wb_addr = 3'(a); end
            2: begin wa_be = 4'b1111; wb_be = 4'b0110; wb_addr = 3'(a); end
            default: begin wa_be = 4'b1011; wb_be = 4'b1101; wb_addr = 3'(a ^ 1); end
          endcase
          ah = (wa_be != 0) && (a == r / 2);
          bh = (wb_be != 0) && (int'(wb_addr) == r / 2);
          if (ah && bh)  begin tt = "R8"; tn = "R9"; end
          else if (bh)   begin tt = "R6"; tn = "R5"; end
          else if (ah)   begin tt = "R10"; tn = "R6"; end
          else           begin tt = "R2"; tn = "R2"; end
          step(tt, tn);
        end
      end
    end
    idle_inputs();

    // R7: read back stored contents after all collisions.
    for (int r = 0; r < 16; r++) begin
      rd_en = 1'b1; rd_addr = 4'(r);
      step("R7", "R7");
    end

    // R3: idle reads while the last-read word is overwritten by both ports.
    rd_en = 1'b0; wa_be = 4'hF; wa_addr = 3'd7; wa_data = 32'hDEAD_BEEF;
    wb_be = 4'h3; wb_addr = 3'd7; wb_data = 32'hCAFE_F00D;
    step("R3", "R3");
    step("R3", "R3");
    idle_inputs();

    // R4: read-port reset without and then with enable.
    rd_srst = 1'b1; rd_en = 1'b0;
    step("R4", "R4");
    rd_en = 1'b1; rd_addr = 4'd14;
    step("R4", "R4");
    rd_srst = 1'b0;
    step("R2", "R2");

    // R1: reset mid-run overrides a colliding read.
    rst = 1'b1; rd_en = 1'b1; rd_addr = 4'd2; wa_be = 4'hF; wa_addr = 3'd1;
    step("R1", "R1");
    rst = 1'b0; idle_inputs();
    step("R3", "R3");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule